// File: doc/BRIEF.md
# Fixed-Point Multiply-Accumulate Unit

This block is a single-cycle multiplier-accumulator for 16-bit fixed-point data. On each enabled clock it takes two 16-bit operands and a 2-bit operation code. It then does one of four things: it loads the product into its accumulator, adds the product to the accumulator, subtracts the product from it, or clears it. A signed/unsigned flag for each operand sets how that operand is read, so signed, unsigned and mixed-format products are all available.

The accumulator is a 40-bit register. The 32-bit product sits below 8 guard bits, so long sums can grow past the 32-bit range without losing their value. The register drives the full-precision output directly, so any following logic can use the result on the very next cycle. A second output gives a 16-bit value taken from the upper half of the 32-bit range. That value can be rounded to nearest, and it is clamped whenever it does not fit. An overflow flag reports when the accumulator has left the signed 32-bit range.

Top module: `fxmac_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the accumulator is cleared. After that edge `acc_full` is 0, `ovf` is 0 and `acc_sat` is 0.
- R2: With `op_en` high and `op_code` = 2'b00, the next `acc_full` is the product of the two operands, sign-extended to 40 bits.
- R3: With `op_en` high and `op_code` = 2'b01, the next `acc_full` is the current accumulator plus the product.
- R4: With `op_en` high and `op_code` = 2'b10, the next `acc_full` is the current accumulator minus the product.
- R5: With `op_en` high and `op_code` = 2'b11, the next `acc_full` is 0, whatever the operands are.
- R6: An operand whose flag (`a_signed` or `b_signed`) is 1 is read as two's complement. An operand whose flag is 0 is read as unsigned, 0 to 65535. For example, 0xFFFF times 0xFFFF is 0x00_FFFE_0001 when both flags are 0, and 1 when both flags are 1.
- R7: While `op_en` is low, `acc_full` does not change, whatever `op_code` and the operands are.
- R8: `ovf` is 1 exactly when the signed value of `acc_full` is above 2^31-1 or below -2^31.
- R9: With `rnd_en` low, `acc_sat` is `acc_full[31:16]` when the value is in the signed 32-bit range. Above that range it is 0x7FFF, and below it it is 0x8000.
- R10: With `rnd_en` high, 2^15 is added to the accumulator value before the R9 selection and clamping. For example, 0x7FFF8000 rounds up to 0x7FFF after clamping.
- R11: The accumulator wraps modulo 2^40 and never saturates. Adding the 32-bit unsigned maximum product 130 times from zero gives a negative 40-bit value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| op_en | input | 1 | Perform the selected operation on this edge |
| op_code | input | 2 | 00 multiply, 01 multiply-add, 10 multiply-subtract, 11 clear |
| opnd_a | input | 16 | First operand |
| opnd_b | input | 16 | Second operand |
| a_signed | input | 1 | 1: `opnd_a` is two's complement; 0: unsigned |
| b_signed | input | 1 | 1: `opnd_b` is two's complement; 0: unsigned |
| rnd_en | input | 1 | Round to nearest before forming `acc_sat` |
| acc_full | output | 40 | Full-precision accumulator value |
| acc_sat | output | 16 | Upper 16 bits of the 32-bit range, clamped |
| ovf | output | 1 | Accumulator is outside the signed 32-bit range |

## Verification
Wrap-around of the 40-bit accumulator is the hardest state to reach from the ports. Even the largest unsigned product fills only the lowest 32 bits, so the sum must be built up over many cycles. The stimulus runs 130 back-to-back multiply-adds of 0xFFFF by 0xFFFF with both flags unsigned, which drives the guard bits through the sign bit. A second corner is the rounding carry that pushes an in-range value past the limit. The stimulus loads 0x7FFF8000 with an unsigned multiply of 0xFFFF by 0x8000 and then sets `rnd_en`.

// File: rtl/fxmac_pkg.sv
// Package: shared widths and the operation encoding of the MAC unit.
// Assumes: the operation code is 2 bits wide, and every module of the
// block takes this encoding.
package fxmac_pkg;
    localparam int OPND_W = 16;
    localparam int ACC_W  = 40;

    typedef enum logic [1:0] {
        OP_MUL = 2'b00,
        OP_MAC = 2'b01,
        OP_MSU = 2'b10,
        OP_CLR = 2'b11
    } mac_op_e;
endpackage

// File: rtl/fxmac_mult.sv
// Module: fxmac_mult
// Widens each operand by one bit and forms a single signed product.
// The widening copies the top bit for a signed operand and puts in zero
// for an unsigned one, so all four format mixes use one multiplier.
// Assumes: ACC_W >= 2*(OPND_W+1).
module fxmac_mult #(
    parameter int OPND_W = fxmac_pkg::OPND_W,
    parameter int ACC_W  = fxmac_pkg::ACC_W
) (
    input  logic [OPND_W-1:0] opnd_a,
    input  logic [OPND_W-1:0] opnd_b,
    input  logic              a_signed,
    input  logic              b_signed,
    output logic [ACC_W-1:0]  prod_ext
);
    localparam int EXT_W  = OPND_W + 1;
    localparam int PROD_W = 2 * EXT_W;

    logic [OPND_W-1:0]       opnd [2];
    logic                    sgn  [2];
    logic signed [EXT_W-1:0] ext  [2];
    logic signed [PROD_W-1:0] prod;

    assign opnd[0] = opnd_a;
    assign opnd[1] = opnd_b;
    assign sgn[0]  = a_signed;
    assign sgn[1]  = b_signed;

    // Widen each operand according to its format flag.
    for (genvar i = 0; i < 2; i++) begin : g_ext
        assign ext[i] = {sgn[i] & opnd[i][OPND_W-1], opnd[i]};
    end

    // One signed multiply covers every format combination.
    assign prod = ext[0] * ext[1];

    // Sign-extend the product to the accumulator width.
    assign prod_ext = {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
endmodule

// File: rtl/fxmac_accum.sv
// Module: fxmac_accum
// Holds the accumulator and applies load, add, subtract or clear on
// enabled edges. Sums wrap modulo 2^ACC_W; the guard bits hold growth.
// Assumes: prod_ext is already sign-extended to ACC_W.
module fxmac_accum
    import fxmac_pkg::*;
#(
    parameter int ACC_W = fxmac_pkg::ACC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_en,
    input  mac_op_e          op,
    input  logic [ACC_W-1:0] prod_ext,
    output logic [ACC_W-1:0] acc_q
);
    logic [ACC_W-1:0] acc_d;

    // Choose the next accumulator value from the operation code.
    always_comb begin
        unique case (op)
            OP_MUL:  acc_d = prod_ext;
            OP_MAC:  acc_d = acc_q + prod_ext;
            OP_MSU:  acc_d = acc_q - prod_ext;
            default: acc_d = '0;
        endcase
    end

    // Accumulator register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (op_en) begin
            acc_q <= acc_d;
        end
    end
endmodule

// File: rtl/fxmac_satout.sv
// Module: fxmac_satout
// Builds the overflow flag and the clamped 16-bit view of the accumulator.
// Rounding adds half an output LSB in a sum one bit wider than the
// accumulator, so the carry can never wrap.
// Assumes: the 16-bit view is the upper half of a 2*OPND_W-bit range.
module fxmac_satout #(
    parameter int OPND_W = fxmac_pkg::OPND_W,
    parameter int ACC_W  = fxmac_pkg::ACC_W
) (
    input  logic [ACC_W-1:0]  acc,
    input  logic              rnd_en,
    output logic [OPND_W-1:0] sat,
    output logic              ovf
);
    localparam int RNG_W = 2 * OPND_W;
    localparam int HI    = RNG_W - 1;
    localparam int GRD_W = ACC_W - HI;

    logic [GRD_W-1:0] acc_top;
    logic [ACC_W:0]   rnd_inc;
    logic [ACC_W:0]   rsum;
    logic [GRD_W:0]   rsum_top;
    logic             rovf;

    // Out of range when the bits above the 32-bit range are not all copies of its sign.
    assign acc_top = acc[ACC_W-1:HI];
    assign ovf     = !((&acc_top) || !(|acc_top));

    // Add half an output LSB when rounding is on.
    assign rnd_inc = {{(ACC_W+1-OPND_W){1'b0}}, rnd_en, {(OPND_W-1){1'b0}}};
    assign rsum    = {acc[ACC_W-1], acc} + rnd_inc;

    // Range test on the rounded value.
    assign rsum_top = rsum[ACC_W:HI];
    assign rovf     = !((&rsum_top) || !(|rsum_top));

    // Clamp by sign, or take the upper half of the range.
    always_comb begin
        if (rovf) begin
            sat = rsum[ACC_W] ? {1'b1, {(OPND_W-1){1'b0}}}
                              : {1'b0, {(OPND_W-1){1'b1}}};
        end else begin
            sat = rsum[HI -: OPND_W];
        end
    end
endmodule

// File: rtl/fxmac_unit.sv
// Module: fxmac_unit (top)
// Single-cycle 16x16 multiply-accumulate with a 40-bit accumulator,
// per-operand format flags, an overflow flag and a clamped 16-bit output.
// Assumes: all inputs are synchronous to clk; rst_n is synchronous.
module fxmac_unit
    import fxmac_pkg::*;
#(
    parameter int OPND_W = fxmac_pkg::OPND_W,
    parameter int ACC_W  = fxmac_pkg::ACC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_en,
    input  logic [1:0]        op_code,
    input  logic [OPND_W-1:0] opnd_a,
    input  logic [OPND_W-1:0] opnd_b,
    input  logic              a_signed,
    input  logic              b_signed,
    input  logic              rnd_en,
    output logic [ACC_W-1:0]  acc_full,
    output logic [OPND_W-1:0] acc_sat,
    output logic              ovf
);
    logic [ACC_W-1:0] prod_ext;
    logic [ACC_W-1:0] acc_q;
    mac_op_e          op;

    // Map the raw code onto the shared encoding.
    assign op = mac_op_e'(op_code);

    fxmac_mult #(.OPND_W(OPND_W), .ACC_W(ACC_W)) u_mult (
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b),
        .a_signed (a_signed),
        .b_signed (b_signed),
        .prod_ext (prod_ext)
    );

    fxmac_accum #(.ACC_W(ACC_W)) u_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_en    (op_en),
        .op       (op),
        .prod_ext (prod_ext),
        .acc_q    (acc_q)
    );

    fxmac_satout #(.OPND_W(OPND_W), .ACC_W(ACC_W)) u_sat (
        .acc    (acc_q),
        .rnd_en (rnd_en),
        .sat    (acc_sat),
        .ovf    (ovf)
    );

    assign acc_full = acc_q;
endmodule

// File: rtl/fxmac_unit_chk.sv
// Module: fxmac_unit_chk
// Property checker attached to fxmac_unit through a bind. It sees only
// the ports of the unit.
module fxmac_unit_chk #(
    parameter int OPND_W = 16,
    parameter int ACC_W  = 40
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_en,
    input logic [1:0]        op_code,
    input logic [OPND_W-1:0] opnd_a,
    input logic [OPND_W-1:0] opnd_b,
    input logic              a_signed,
    input logic              b_signed,
    input logic              rnd_en,
    input logic [ACC_W-1:0]  acc_full,
    input logic [OPND_W-1:0] acc_sat,
    input logic              ovf
);
    localparam logic signed [ACC_W-1:0] MAX32 = ACC_W'((64'sd1 <<< (2*OPND_W-1)) - 64'sd1);
    localparam logic signed [ACC_W-1:0] MIN32 = ACC_W'(-(64'sd1 <<< (2*OPND_W-1)));
    localparam logic [OPND_W-1:0] SAT_POS = {1'b0, {(OPND_W-1){1'b1}}};
    localparam logic [OPND_W-1:0] SAT_NEG = {1'b1, {(OPND_W-1){1'b0}}};

    logic signed [ACC_W-1:0] a_sx, b_sx, prod_ss, acc_s;

    // Reference product for the case where both operands are signed.
    assign a_sx    = {{(ACC_W-OPND_W){opnd_a[OPND_W-1]}}, opnd_a};
    assign b_sx    = {{(ACC_W-OPND_W){opnd_b[OPND_W-1]}}, opnd_b};
    assign prod_ss = a_sx * b_sx;
    assign acc_s   = acc_full;

    // R1: reset empties the accumulator
    p_reset_clear_r1: assert property (@(posedge clk) !rst_n |=> acc_full == '0);

    // R2: a plain signed multiply loads the product
    p_mul_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_en && op_code == 2'b00 && a_signed && b_signed) |=> acc_full == $past(prod_ss));

    // R5: clear leaves zero
    p_clear_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_en && op_code == 2'b11) |=> acc_full == '0);

    // R7: disabled cycles hold the accumulator
    p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !op_en |=> $stable(acc_full));

    // R8: flag tracks the signed 32-bit range
    p_ovf_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ovf == ((acc_s > MAX32) || (acc_s < MIN32)));

    // R9: unrounded clamp follows the sign
    p_sat_clamp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !rnd_en) |-> acc_sat == (acc_full[ACC_W-1] ? SAT_NEG : SAT_POS));
endmodule

bind fxmac_unit fxmac_unit_chk #(.OPND_W(OPND_W), .ACC_W(ACC_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_en    (op_en),
    .op_code  (op_code),
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b),
    .a_signed (a_signed),
    .b_signed (b_signed),
    .rnd_en   (rnd_en),
    .acc_full (acc_full),
    .acc_sat  (acc_sat),
    .ovf      (ovf)
);

// File: tb/fxmac_unit_test.sv
// Bench for fxmac_unit: an integer reference model, compared after every clock.
module fxmac_unit_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_en = 1'b0;
    logic [1:0]  op_code = 2'b00;
    logic [15:0] opnd_a = '0, opnd_b = '0;
    logic        a_signed = 1'b0, b_signed = 1'b0, rnd_en = 1'b0;
    logic [39:0] acc_full;
    logic [15:0] acc_sat;
    logic        ovf;

    int     n_chk = 0;
    int     n_bad = 0;
    longint m_acc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fxmac_unit uut (
        .clk(clk), .rst_n(rst_n), .op_en(op_en), .op_code(op_code),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .a_signed(a_signed), .b_signed(b_signed),
        .rnd_en(rnd_en), .acc_full(acc_full), .acc_sat(acc_sat), .ovf(ovf)
    );

    function automatic longint wrap40(input longint v);
        longint m;
        m = v & ((64'sd1 <<< 40) - 1);
        if (m[39]) m = m - (64'sd1 <<< 40);
        return m;
    endfunction

    function automatic longint opval(input logic [15:0] v, input logic s);
        return s ? longint'($signed(v)) : longint'(v);
    endfunction

    function automatic logic [15:0] exp_sat(input longint acc, input logic rnd);
        longint v;
        v = acc + (rnd ? 64'sd32768 : 64'sd0);
        if (v > 64'sd2147483647) return 16'h7FFF;
        if (v < -64'sd2147483648) return 16'h8000;
        return v[31:16];
    endfunction

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Compare all three outputs against the model.
    task automatic compare(input string tag);
        logic m_ovf;
        m_ovf = (m_acc > 64'sd2147483647) || (m_acc < -64'sd2147483648);
        chk(tag, longint'(acc_full), longint'(m_acc[39:0]));
        chk("R8", longint'(ovf), longint'(m_ovf));
        chk(rnd_en ? "R10" : "R9", longint'(acc_sat), longint'(exp_sat(m_acc, rnd_en)));
    endtask

    // Drive one cycle from a falling edge, update the model at the rising edge, check after.
    task automatic step(input logic en, input logic [1:0] op, input logic [15:0] av,
                        input logic [15:0] bv, input logic as, input logic bs,
                        input logic rnd, input string tag);
        longint p;
        op_en = en; op_code = op; opnd_a = av; opnd_b = bv;
        a_signed = as; b_signed = bs; rnd_en = rnd;
        @(posedge clk);
        p = opval(av, as) * opval(bv, bs);
        if (!rst_n) m_acc = 0;
        else if (en) begin
            case (op)
                2'b00: m_acc = wrap40(p);
                2'b01: m_acc = wrap40(m_acc + p);
                2'b10: m_acc = wrap40(m_acc - p);
                default: m_acc = 0;
            endcase
        end
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        m_acc = 0;
        compare("R1");
        rst_n = 1'b1;

        // R2 / R6: multiply in several formats
        step(1, 2'b00, 16'd3, 16'hFFFB, 1, 1, 0, "R2");
        step(1, 2'b00, 16'h7FFF, 16'h7FFF, 1, 1, 0, "R2");
        step(1, 2'b00, 16'h8000, 16'h8000, 1, 1, 0, "R2");
        step(1, 2'b00, 16'hFFFF, 16'hFFFF, 0, 0, 0, "R6");
        step(1, 2'b00, 16'hFFFF, 16'hFFFF, 1, 1, 0, "R6");
        step(1, 2'b00, 16'hFFFF, 16'hFFFF, 1, 0, 0, "R6");
        step(1, 2'b00, 16'h1234, 16'hFF00, 0, 1, 0, "R6");

        // R3 / R4: accumulate and subtract
        step(1, 2'b01, 16'h4000, 16'h4000, 1, 1, 0, "R3");
        step(1, 2'b01, 16'h7FFF, 16'h7FFF, 1, 1, 0, "R3");
        step(1, 2'b10, 16'hFFFF, 16'hFFFF, 0, 0, 0, "R4");
        step(1, 2'b10, 16'hFFFF, 16'hFFFF, 0, 0, 0, "R4");
        step(1, 2'b10, 16'h8000, 16'h7FFF, 1, 1, 0, "R4");

        // R7: disabled cycles with changing inputs
        step(0, 2'b11, 16'h5555, 16'hAAAA, 1, 0, 0, "R7");
        step(0, 2'b00, 16'h0001, 16'h0001, 0, 0, 0, "R7");
        step(0, 2'b10, 16'hFFFF, 16'hFFFF, 0, 0, 1, "R7");

        // R5: clear
        step(1, 2'b11, 16'hFFFF, 16'hFFFF, 0, 0, 0, "R5");

        // R9 / R10: rounding and clamping
        step(1, 2'b00, 16'h0003, 16'h8000, 0, 0, 1, "R10");
        step(1, 2'b00, 16'hFFFF, 16'h8000, 0, 0, 0, "R9");
        step(0, 2'b00, 16'h0000, 16'h0000, 0, 0, 1, "R10");
        step(1, 2'b01, 16'h0001, 16'h0001, 0, 0, 0, "R9");
        step(1, 2'b10, 16'hFFFF, 16'hFFFF, 0, 0, 0, "R9");
        step(1, 2'b10, 16'hFFFF, 16'hFFFF, 0, 0, 1, "R10");

        // R11: long unsigned accumulation wraps through the guard bits
        step(1, 2'b11, 16'h0000, 16'h0000, 0, 0, 0, "R5");
        for (int i = 0; i < 130; i++) step(1, 2'b01, 16'hFFFF, 16'hFFFF, 0, 0, 0, "R11");
        chk("R11", longint'(acc_full[39]), 64'sd1);

        // Mixed random traffic
        for (int i = 0; i < 300; i++) begin
            logic [1:0] rop;
            rop = 2'($urandom_range(0, 9) < 8 ? $urandom_range(0, 2) : 3);
            step(1'($urandom_range(0, 7) != 0), rop, 16'($urandom), 16'($urandom),
                 1'($urandom), 1'($urandom), 1'($urandom), "R3");
        end

        // R1: reset in the middle of operation
        rst_n = 1'b0;
        step(1, 2'b01, 16'h7FFF, 16'h7FFF, 1, 1, 0, "R1");
        rst_n = 1'b1;
        step(1, 2'b01, 16'h0002, 16'h0003, 1, 1, 0, "R3");

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule